// File: doc/BRIEF.md
# Linked-List Segment Queue Manager

This block keeps many packet queues in one shared pointer memory. Packet data lives elsewhere in a segment-aligned data memory cut into fixed 64-byte segments, so a segment's address is just an index into the pointer memory. Each pointer entry holds the index of the next segment and a flag that marks the last segment of a packet. Unused segments form a free list threaded through the same memory. A queue table keeps the head index, tail index and segment count of every queue.

Clients post commands into one small FIFO per port. A round-robin arbiter picks the next non-empty FIFO whenever the execution engine is idle. The engine runs the command as a short sequence of pointer-memory steps and returns one response. The response carries the data-memory segment address that the data path should use, plus the number of segments the command touched. The steps are ordered so that the first access of a command already settles that address, so the data transfer can start early. Besides segment commands, the block supports packet commands that walk the list up to the end-of-packet mark: dropping a whole packet, and moving a packet to another queue.

Top module: `segq_mgr`

## Requirements
- R1: After reset every queue is empty and all NUM_SEGS segments sit on the free list in ascending order from index 0, so the first enqueue returns address 0. Every cmd_ready is high and rsp_valid is low.
- R2: Enqueue (op code 0) takes the segment at the free-list head, returns it in rsp_addr with rsp_nseg = 1, and appends it at the tail of the queue named by the queue id, tagged with cmd_eop.
- R3: Dequeue (op code 1) returns the head segment of the queue in arrival order with rsp_nseg = 1. It pushes that segment onto the free-list head in the same command, so the next enqueue reuses it.
- R4: Delete segment (op code 2) removes and frees the head segment exactly as a dequeue does, and reports it in rsp_addr.
- R5: Overwrite (op code 4) returns the head segment address with rsp_nseg = 1 and changes no queue or free-list state.
- R6: Delete packet (op code 3) frees segments from the queue head up to and including the first segment flagged end-of-packet, or up to the end of the queue if no segment is flagged. rsp_addr is the first segment and rsp_nseg is the number freed. Segments are freed in list order, so the last one freed is the next one allocated.
- R7: Move packet (op code 5) detaches the head packet (bounded as in R6) from the source queue and appends it, in order, to the tail of the destination queue given by cmd_dst. When source and destination are the same queue, the packet rotates to the tail.
- R8: A dequeue, delete, overwrite or move on an empty queue, an enqueue while the free list is empty, and op codes 6 and 7 all return rsp_err = 1 with rsp_nseg = 0 and leave all state unchanged.
- R9: Commands from one port run in the order they were accepted. cmd_ready is low while that port's FIFO is full. When several FIFOs hold commands, the engine serves them in round-robin order.
- R10: The free-list length plus the lengths of all queues always equals NUM_SEGS. Enqueues therefore succeed exactly until NUM_SEGS segments are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NUM_PORTS | Per-port command valid |
| cmd_ready | output | NUM_PORTS | Per-port FIFO has room |
| cmd_op | input | NUM_PORTS x 3 | Per-port op code |
| cmd_qid | input | NUM_PORTS x QID_W | Per-port target or source queue |
| cmd_dst | input | NUM_PORTS x QID_W | Per-port destination queue for a move |
| cmd_eop | input | NUM_PORTS | End-of-packet flag for an enqueue |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_port | output | PORT_W | Port that issued the command |
| rsp_op | output | 3 | Op code of the command |
| rsp_err | output | 1 | Command was rejected |
| rsp_addr | output | SEG_W | Data-memory segment address |
| rsp_nseg | output | CNT_W | Segments touched by the command |

## Verification
The assertions assume that a FIFO is popped only when the arbiter has granted a non-empty port and that the engine starts a command only while idle. They also assume that queue ids index a table sized to a power of two, so every id is legal. The bench respects the port handshake: it holds a command until cmd_ready is seen high, and it issues random commands one at a time so the reference model applies them in a known order. Concurrency is exercised only in bursts from a single port, which run in order, or in bursts of overwrites, which leave the state unchanged whatever order the arbiter picks.

// File: rtl/segq_pkg.sv
package segq_pkg;
   localparam int OP_W = 3;
   localparam logic [OP_W-1:0] OP_ENQ     = 3'd0;
   localparam logic [OP_W-1:0] OP_DEQ     = 3'd1;
   localparam logic [OP_W-1:0] OP_DEL_SEG = 3'd2;
   localparam logic [OP_W-1:0] OP_DEL_PKT = 3'd3;
   localparam logic [OP_W-1:0] OP_OVR     = 3'd4;
   localparam logic [OP_W-1:0] OP_MOVE    = 3'd5;

   typedef enum logic [2:0] {
      ST_IDLE, ST_FIRST, ST_ENQ_LINK, ST_DEL_WALK, ST_MV_WALK, ST_MV_LINK
   } segq_state_e;
endpackage

// File: rtl/segq_cmd_fifo.sv
module segq_cmd_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   output logic             full,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty
);
   initial begin : p_param_chk
      assert (DEPTH >= 2 && (1 << AW) == DEPTH) else $error("DEPTH must be a power of two >= 2");
   end

   logic [WIDTH-1:0] store [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [AW:0]      fill;

   assign full  = (fill == (AW+1)'(DEPTH));
   assign empty = (fill == '0);
   assign dout  = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         if (pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({push, pop})
            2'b10:   fill <= fill + (AW+1)'(1);
            2'b01:   fill <= fill - (AW+1)'(1);
            default: fill <= fill;
         endcase
      end
   end

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) fill <= (AW+1)'(DEPTH)) else $error("fifo overfilled"); // R9
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty) else $error("pop of empty fifo"); // R9
endmodule

// File: rtl/segq_rr_arb.sv
module segq_rr_arb #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic         en,
   output logic [N-1:0] grant
);
   generate
      if (N == 1) begin : g_single
         assign grant = req & {N{en}};
      end else begin : g_rr
         localparam int IW = $clog2(N);
         logic [IW-1:0] last;
         int            gidx;

         always_comb begin
            grant = '0;
            gidx  = -1;
            for (int k = 1; k <= N; k++) begin
               int idx;
               idx = (int'(last) + k) % N;
               if (gidx < 0 && req[idx]) gidx = idx;
            end
            if (en && gidx >= 0) grant[gidx] = 1'b1;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) last <= IW'(N - 1);
            else if (en && gidx >= 0) last <= IW'(gidx);
         end
      end
   endgenerate

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)) else $error("multiple grants"); // R9
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req) == '0) else $error("grant without request"); // R9
endmodule

// File: rtl/segq_engine.sv
module segq_engine
   import segq_pkg::*;
#(
   parameter int NUM_QUEUES = 4,
   parameter int NUM_SEGS   = 16,
   parameter int PORT_W     = 1,
   localparam int QID_W = $clog2(NUM_QUEUES),
   localparam int SEG_W = $clog2(NUM_SEGS),
   localparam int CNT_W = $clog2(NUM_SEGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   in_op,
   input  logic [QID_W-1:0]  in_q,
   input  logic [QID_W-1:0]  in_dst,
   input  logic              in_eop,
   input  logic [PORT_W-1:0] in_port,
   output logic              idle,
   output logic              rsp_valid,
   output logic [PORT_W-1:0] rsp_port,
   output logic [OP_W-1:0]   rsp_op,
   output logic              rsp_err,
   output logic [SEG_W-1:0]  rsp_addr,
   output logic [CNT_W-1:0]  rsp_nseg
);
   // shared pointer memory: next index and end-of-packet mark per segment
   logic [SEG_W-1:0] pm_nxt [NUM_SEGS];
   logic             pm_eop [NUM_SEGS];
   // queue table
   logic [SEG_W-1:0] q_head [NUM_QUEUES];
   logic [SEG_W-1:0] q_tail [NUM_QUEUES];
   logic [CNT_W-1:0] q_cnt  [NUM_QUEUES];
   // free list
   logic [SEG_W-1:0] f_head;
   logic [CNT_W-1:0] f_cnt;

   segq_state_e       st;
   logic [OP_W-1:0]   c_op;
   logic [QID_W-1:0]  c_q, c_dst;
   logic              c_eop;
   logic [PORT_W-1:0] c_port;
   logic [SEG_W-1:0]  first, cur, endp;
   logic [CNT_W-1:0]  n;

   logic [CNT_W-1:0] src_cnt, dst_cnt, rem;
   logic [SEG_W-1:0] src_head, cur_nxt, end_nxt;
   logic             src_empty, cur_eop, del_last, mv_last;

   assign idle      = (st == ST_IDLE);
   assign src_cnt   = q_cnt[c_q];
   assign dst_cnt   = q_cnt[c_dst];
   assign src_head  = q_head[c_q];
   assign src_empty = (src_cnt == '0);
   assign cur_nxt   = pm_nxt[cur];
   assign cur_eop   = pm_eop[cur];
   assign end_nxt   = pm_nxt[endp];
   assign rem       = src_cnt - n;
   assign del_last  = cur_eop || (src_cnt == CNT_W'(1));
   assign mv_last   = cur_eop || ((n + CNT_W'(1)) == src_cnt);

   // response decision
   logic             r_fire, r_err;
   logic [SEG_W-1:0] r_addr;
   logic [CNT_W-1:0] r_nseg;

   always_comb begin
      r_fire = 1'b0;
      r_err  = 1'b0;
      r_addr = first;
      r_nseg = '0;
      case (st)
         ST_FIRST: begin
            case (c_op)
               OP_ENQ: if (f_cnt == '0) begin r_fire = 1'b1; r_err = 1'b1; end
               OP_DEQ, OP_DEL_SEG, OP_OVR: begin
                  r_fire = 1'b1;
                  if (src_empty) r_err = 1'b1;
                  else begin r_addr = src_head; r_nseg = CNT_W'(1); end
               end
               OP_DEL_PKT, OP_MOVE: if (src_empty) begin r_fire = 1'b1; r_err = 1'b1; end
               default: begin r_fire = 1'b1; r_err = 1'b1; end
            endcase
         end
         ST_ENQ_LINK: begin r_fire = 1'b1; r_nseg = CNT_W'(1); end
         ST_DEL_WALK: if (del_last) begin r_fire = 1'b1; r_nseg = n + CNT_W'(1); end
         ST_MV_LINK:  begin r_fire = 1'b1; r_nseg = n; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_port  <= '0;
         rsp_op    <= '0;
         rsp_err   <= 1'b0;
         rsp_addr  <= '0;
         rsp_nseg  <= '0;
      end else begin
         rsp_valid <= r_fire;
         if (r_fire) begin
            rsp_port <= c_port;
            rsp_op   <= c_op;
            rsp_err  <= r_err;
            rsp_addr <= r_addr;
            rsp_nseg <= r_nseg;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         f_head <= '0;
         f_cnt  <= CNT_W'(NUM_SEGS);
         for (int i = 0; i < NUM_SEGS; i++) begin
            pm_nxt[i] <= SEG_W'((i + 1) % NUM_SEGS);
            pm_eop[i] <= 1'b0;
         end
         for (int i = 0; i < NUM_QUEUES; i++) begin
            q_head[i] <= '0;
            q_tail[i] <= '0;
            q_cnt[i]  <= '0;
         end
         c_op <= '0; c_q <= '0; c_dst <= '0; c_eop <= 1'b0; c_port <= '0;
         first <= '0; cur <= '0; endp <= '0; n <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               c_op <= in_op; c_q <= in_q; c_dst <= in_dst; c_eop <= in_eop; c_port <= in_port;
               st <= ST_FIRST;
            end
            ST_FIRST: begin
               st <= ST_IDLE;
               case (c_op)
                  OP_ENQ: if (f_cnt != '0) begin
                     first          <= f_head;
                     f_head         <= pm_nxt[f_head];
                     f_cnt          <= f_cnt - CNT_W'(1);
                     pm_eop[f_head] <= c_eop;
                     st             <= ST_ENQ_LINK;
                  end
                  OP_DEQ, OP_DEL_SEG: if (!src_empty) begin
                     q_head[c_q]      <= pm_nxt[src_head];
                     q_cnt[c_q]       <= src_cnt - CNT_W'(1);
                     pm_nxt[src_head] <= f_head;
                     f_head           <= src_head;
                     f_cnt            <= f_cnt + CNT_W'(1);
                  end
                  OP_DEL_PKT: if (!src_empty) begin
                     first <= src_head; cur <= src_head; n <= '0; st <= ST_DEL_WALK;
                  end
                  OP_MOVE: if (!src_empty) begin
                     first <= src_head; cur <= src_head; n <= '0; st <= ST_MV_WALK;
                  end
                  default: ;
               endcase
            end
            ST_ENQ_LINK: begin
               if (src_empty) q_head[c_q] <= first;
               else pm_nxt[q_tail[c_q]] <= first;
               q_tail[c_q] <= first;
               q_cnt[c_q]  <= src_cnt + CNT_W'(1);
               st          <= ST_IDLE;
            end
            ST_DEL_WALK: begin
               pm_nxt[cur] <= f_head;
               f_head      <= cur;
               f_cnt       <= f_cnt + CNT_W'(1);
               q_head[c_q] <= cur_nxt;
               q_cnt[c_q]  <= src_cnt - CNT_W'(1);
               n           <= n + CNT_W'(1);
               cur         <= cur_nxt;
               if (del_last) st <= ST_IDLE;
            end
            ST_MV_WALK: begin
               n <= n + CNT_W'(1);
               if (mv_last) begin endp <= cur; st <= ST_MV_LINK; end
               else cur <= cur_nxt;
            end
            ST_MV_LINK: begin
               st <= ST_IDLE;
               if (c_q == c_dst) begin
                  if (rem != '0) begin
                     q_head[c_q]         <= end_nxt;
                     pm_nxt[q_tail[c_q]] <= first;
                     q_tail[c_q]         <= endp;
                  end
               end else begin
                  q_head[c_q] <= end_nxt;
                  q_cnt[c_q]  <= rem;
                  if (dst_cnt == '0) q_head[c_dst] <= first;
                  else pm_nxt[q_tail[c_dst]] <= first;
                  q_tail[c_dst] <= endp;
                  q_cnt[c_dst]  <= dst_cnt + n;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   int q_sum;
   always_comb begin
      q_sum = 0;
      for (int i = 0; i < NUM_QUEUES; i++) q_sum += int'(q_cnt[i]);
   end

   AST_SEG_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n) (int'(f_cnt) + q_sum + ((st == ST_ENQ_LINK) ? 1 : 0)) == NUM_SEGS) else $error("segments lost or duplicated"); // R10
   AST_ERR_KEEPS_FREE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_err) |-> $stable(f_cnt)) else $error("error changed free list"); // R8
   AST_DEQ_FREES_HEAD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_err && rsp_op == OP_DEQ) |-> (f_head == rsp_addr)) else $error("dequeued segment not on free head"); // R3
   AST_OVR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_err && rsp_op == OP_OVR) |-> $stable(f_cnt)) else $error("overwrite changed free list"); // R5
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start |-> idle) else $error("start while busy"); // R9
endmodule

// File: rtl/segq_mgr.sv
module segq_mgr
   import segq_pkg::*;
#(
   parameter int NUM_PORTS  = 2,
   parameter int NUM_QUEUES = 4,
   parameter int NUM_SEGS   = 16,
   parameter int FIFO_DEPTH = 4,
   localparam int QID_W  = $clog2(NUM_QUEUES),
   localparam int SEG_W  = $clog2(NUM_SEGS),
   localparam int CNT_W  = $clog2(NUM_SEGS + 1),
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_PORTS-1:0]             cmd_valid,
   output logic [NUM_PORTS-1:0]             cmd_ready,
   input  logic [NUM_PORTS-1:0][OP_W-1:0]   cmd_op,
   input  logic [NUM_PORTS-1:0][QID_W-1:0]  cmd_qid,
   input  logic [NUM_PORTS-1:0][QID_W-1:0]  cmd_dst,
   input  logic [NUM_PORTS-1:0]             cmd_eop,
   output logic                             rsp_valid,
   output logic [PORT_W-1:0]                rsp_port,
   output logic [OP_W-1:0]                  rsp_op,
   output logic                             rsp_err,
   output logic [SEG_W-1:0]                 rsp_addr,
   output logic [CNT_W-1:0]                 rsp_nseg
);
   localparam int FW = OP_W + 2 * QID_W + 1;

   initial begin : p_param_chk
      assert (NUM_QUEUES >= 2 && (1 << QID_W) == NUM_QUEUES) else $error("NUM_QUEUES must be a power of two >= 2");
      assert (NUM_SEGS >= 2 && (1 << SEG_W) == NUM_SEGS) else $error("NUM_SEGS must be a power of two >= 2");
      assert (NUM_PORTS >= 1) else $error("NUM_PORTS must be >= 1");
   end

   logic [NUM_PORTS-1:0] f_full, f_empty, grant;
   logic [FW-1:0]        f_dout [NUM_PORTS];
   logic                 eng_idle;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         segq_cmd_fifo #(.WIDTH(FW), .DEPTH(FIFO_DEPTH)) fifo_i (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (cmd_valid[p] & ~f_full[p]),
            .din   ({cmd_op[p], cmd_qid[p], cmd_dst[p], cmd_eop[p]}),
            .full  (f_full[p]),
            .pop   (grant[p]),
            .dout  (f_dout[p]),
            .empty (f_empty[p])
         );
      end
   endgenerate

   assign cmd_ready = ~f_full;

   segq_rr_arb #(.N(NUM_PORTS)) arb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (~f_empty),
      .en    (eng_idle),
      .grant (grant)
   );

   logic [FW-1:0]     sel;
   logic [PORT_W-1:0] sel_port;
   always_comb begin
      sel      = '0;
      sel_port = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (grant[p]) begin
            sel      = f_dout[p];
            sel_port = PORT_W'(p);
         end
      end
   end

   segq_engine #(.NUM_QUEUES(NUM_QUEUES), .NUM_SEGS(NUM_SEGS), .PORT_W(PORT_W)) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (|grant),
      .in_op     (sel[FW-1 -: OP_W]),
      .in_q      (sel[2*QID_W : QID_W+1]),
      .in_dst    (sel[QID_W:1]),
      .in_eop    (sel[0]),
      .in_port   (sel_port),
      .idle      (eng_idle),
      .rsp_valid (rsp_valid),
      .rsp_port  (rsp_port),
      .rsp_op    (rsp_op),
      .rsp_err   (rsp_err),
      .rsp_addr  (rsp_addr),
      .rsp_nseg  (rsp_nseg)
   );
endmodule

// File: tb/segq_mgr_tb_top.sv
`timescale 1ns/1ps
module segq_mgr_tb_top;
   localparam int NP = 2;
   localparam int NQ = 4;
   localparam int NS = 16;
   localparam int FD = 4;
   localparam int QW = 2;
   localparam int SW = 4;
   localparam int CW = 5;

   logic clk = 1'b0;
   logic rst_n;
   logic [NP-1:0]         cmd_valid, cmd_ready, cmd_eop;
   logic [NP-1:0][2:0]    cmd_op;
   logic [NP-1:0][QW-1:0] cmd_qid, cmd_dst;
   logic                  rsp_valid, rsp_err;
   logic [0:0]            rsp_port;
   logic [2:0]            rsp_op;
   logic [SW-1:0]         rsp_addr;
   logic [CW-1:0]         rsp_nseg;

   always #4 clk = ~clk;

   segq_mgr #(.NUM_PORTS(NP), .NUM_QUEUES(NQ), .NUM_SEGS(NS), .FIFO_DEPTH(FD)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_qid(cmd_qid), .cmd_dst(cmd_dst), .cmd_eop(cmd_eop),
      .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_op(rsp_op), .rsp_err(rsp_err),
      .rsp_addr(rsp_addr), .rsp_nseg(rsp_nseg)
   );

   int nchk = 0, nfail = 0;
   bit finished = 0;

   // response log
   int lg_port [1024], lg_op [1024], lg_err [1024], lg_addr [1024], lg_nseg [1024];
   int rcnt = 0;
   always @(negedge clk) begin
      if (rst_n && rsp_valid && rcnt < 1024) begin
         lg_port[rcnt] = int'(rsp_port); lg_op[rcnt] = int'(rsp_op); lg_err[rcnt] = int'(rsp_err);
         lg_addr[rcnt] = int'(rsp_addr); lg_nseg[rcnt] = int'(rsp_nseg);
         rcnt++;
      end
   end

   // reference model
   int mq [NQ][NS]; bit me [NQ][NS]; int mc [NQ];
   int mf [NS]; int mfc;

   task automatic model_reset();
      for (int i = 0; i < NS; i++) mf[i] = i;
      mfc = NS;
      for (int q = 0; q < NQ; q++) mc[q] = 0;
   endtask

   task automatic free_push(int s);
      for (int i = mfc; i > 0; i--) mf[i] = mf[i-1];
      mf[0] = s; mfc++;
   endtask

   task automatic q_pop(int q, output int s, output bit e);
      s = mq[q][0]; e = me[q][0];
      for (int i = 0; i < mc[q] - 1; i++) begin mq[q][i] = mq[q][i+1]; me[q][i] = me[q][i+1]; end
      mc[q]--;
   endtask

   task automatic q_push(int q, int s, bit e);
      mq[q][mc[q]] = s; me[q][mc[q]] = e; mc[q]++;
   endtask

   task automatic model(int op, int q, int d, bit eop, output bit err, output int addr, output int nseg);
      int s; bit e; int tmp_s [NS]; bit tmp_e [NS];
      err = 0; addr = 0; nseg = 0;
      case (op)
         0: if (mfc == 0) err = 1;
            else begin
               addr = mf[0];
               for (int i = 0; i < mfc - 1; i++) mf[i] = mf[i+1];
               mfc--; q_push(q, addr, eop); nseg = 1;
            end
         1, 2: if (mc[q] == 0) err = 1;
            else begin q_pop(q, s, e); free_push(s); addr = s; nseg = 1; end
         3: if (mc[q] == 0) err = 1;
            else begin
               addr = mq[q][0];
               do begin q_pop(q, s, e); free_push(s); nseg++; end while (!e && mc[q] > 0);
            end
         4: if (mc[q] == 0) err = 1; else begin addr = mq[q][0]; nseg = 1; end
         5: if (mc[q] == 0) err = 1;
            else begin
               addr = mq[q][0];
               do begin q_pop(q, s, e); tmp_s[nseg] = s; tmp_e[nseg] = e; nseg++; end while (!e && mc[q] > 0);
               for (int i = 0; i < nseg; i++) q_push(d, tmp_s[i], tmp_e[i]);
            end
         default: err = 1;
      endcase
   endtask

   function automatic string req_of(int op);
      case (op)
         0: return "R2"; 1: return "R3"; 2: return "R4";
         3: return "R6"; 4: return "R5"; 5: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_rsp(int idx, int p, int op, bit e_err, int e_addr, int e_nseg);
      string rq;
      rq = e_err ? "R8" : req_of(op);
      check(lg_err[idx] == int'(e_err), rq, "rsp_err", lg_err[idx], int'(e_err));
      check(lg_op[idx] == op && lg_port[idx] == p, "R9", "rsp op/port", lg_op[idx]*16 + lg_port[idx], op*16 + p);
      if (e_err) check(lg_nseg[idx] == 0, "R8", "error nseg", lg_nseg[idx], 0);
      else begin
         check(lg_addr[idx] == e_addr, rq, "rsp_addr", lg_addr[idx], e_addr);
         check(lg_nseg[idx] == e_nseg, rq, "rsp_nseg", lg_nseg[idx], e_nseg);
      end
   endtask

   task automatic wait_rsp(int target);
      int t = 0;
      while (rcnt < target && t < 300) begin @(negedge clk); t++; end
      if (rcnt < target) check(0, "R9", "response count", rcnt, target);
   endtask

   task automatic drive(int p, int op, int q, int d, bit eop);
      cmd_op[p] = 3'(op); cmd_qid[p] = QW'(q); cmd_dst[p] = QW'(d); cmd_eop[p] = eop; cmd_valid[p] = 1'b1;
   endtask

   task automatic run_cmd(int p, int op, int q, int d, bit eop, output bit got_err);
      bit e_err; int e_addr, e_nseg, base;
      model(op, q, d, eop, e_err, e_addr, e_nseg);
      base = rcnt;
      @(negedge clk);
      drive(p, op, q, d, eop);
      while (!cmd_ready[p]) @(negedge clk);
      @(negedge clk);
      cmd_valid[p] = 1'b0;
      wait_rsp(base + 1);
      if (rcnt > base) check_rsp(base, p, op, e_err, e_addr, e_nseg);
      got_err = e_err;
   endtask

   bit ex_err [16]; int ex_addr [16], ex_nseg [16];

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++; nfail++;
         $display("FAIL R9 watchdog: actual 0 expected 1");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin : main
      bit ge; int base, okcnt, free_exp; bit saw_full;
      void'($urandom(32'h5EED_0A17));
      rst_n = 1'b0; cmd_valid = '0; cmd_op = '0; cmd_qid = '0; cmd_dst = '0; cmd_eop = '0;
      model_reset();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
      check(cmd_ready == '1, "R1", "cmd_ready after reset", int'(cmd_ready), 3);

      // R1: first allocation is segment 0
      run_cmd(0, 0, 0, 0, 1'b1, ge);
      check(lg_addr[0] == 0, "R1", "first enqueue address", lg_addr[0], 0);

      // R9: burst of enqueues from one port fills its FIFO and stays in order
      base = rcnt; saw_full = 0;
      @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         model(0, 1, 0, 1'b0, ex_err[i], ex_addr[i], ex_nseg[i]);
         drive(0, 0, 1, 0, 1'b0);
         while (!cmd_ready[0]) begin saw_full = 1; @(negedge clk); end
         @(negedge clk);
      end
      cmd_valid[0] = 1'b0;
      wait_rsp(base + 10);
      check(saw_full, "R9", "cmd_ready dropped when FIFO full", int'(saw_full), 1);
      for (int i = 0; i < 10; i++) check_rsp(base + i, 0, 0, ex_err[i], ex_addr[i], ex_nseg[i]);

      // R9: both ports loaded, grants alternate; overwrite leaves state alone (R5)
      model(4, 1, 0, 1'b0, ex_err[0], ex_addr[0], ex_nseg[0]);
      base = rcnt;
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         drive(0, 4, 1, 0, 1'b0); drive(1, 4, 1, 0, 1'b0);
         while (cmd_ready != '1) @(negedge clk);
         @(negedge clk);
      end
      cmd_valid = '0;
      wait_rsp(base + 6);
      for (int i = 0; i < 6; i++) check_rsp(base + i, lg_port[base + i], 4, 1'b0, ex_addr[0], 1);
      for (int i = 1; i < 6; i++)
         check(lg_port[base+i] != lg_port[base+i-1], "R9", "round-robin alternation", lg_port[base+i], 1 - lg_port[base+i-1]);

      // R3 / R4 / R5 directed
      run_cmd(1, 1, 1, 0, 1'b0, ge);   // dequeue head of q1
      run_cmd(0, 0, 0, 0, 1'b0, ge);   // reuses the freed segment (R3)
      run_cmd(1, 2, 1, 0, 1'b0, ge);   // delete segment (R4)
      run_cmd(0, 4, 0, 0, 1'b0, ge);   // overwrite (R5)
      run_cmd(0, 1, 0, 0, 1'b0, ge);   // same head comes out (R5)

      // R6 / R7 packets
      run_cmd(0, 0, 2, 0, 1'b0, ge); run_cmd(0, 0, 2, 0, 1'b0, ge); run_cmd(0, 0, 2, 0, 1'b1, ge);
      run_cmd(1, 0, 2, 0, 1'b0, ge); run_cmd(1, 0, 2, 0, 1'b1, ge); run_cmd(1, 0, 2, 0, 1'b1, ge);
      run_cmd(0, 5, 2, 3, 1'b0, ge);   // move 3-seg packet q2 -> q3
      run_cmd(1, 5, 2, 2, 1'b0, ge);   // rotate within q2
      run_cmd(0, 3, 2, 0, 1'b0, ge);   // delete 1-seg packet
      run_cmd(0, 1, 2, 0, 1'b0, ge);
      run_cmd(1, 3, 3, 0, 1'b0, ge);   // delete moved packet
      run_cmd(0, 0, 3, 0, 1'b0, ge);   // reuses last freed (R6)

      // R8 errors
      run_cmd(0, 1, 3, 0, 1'b0, ge);   // q3 now holds one -> ok
      run_cmd(0, 1, 3, 0, 1'b0, ge);   // empty -> error
      run_cmd(1, 3, 3, 0, 1'b0, ge);
      run_cmd(1, 5, 3, 0, 1'b0, ge);
      run_cmd(0, 6, 0, 0, 1'b0, ge);
      run_cmd(1, 7, 1, 0, 1'b0, ge);

      // R10: enqueues succeed exactly until all segments are queued
      free_exp = NS;
      for (int q = 0; q < NQ; q++) free_exp -= mc[q];
      okcnt = 0;
      for (int i = 0; i <= free_exp; i++) begin
         run_cmd(i % 2, 0, 0, 0, (i % 3) == 0, ge);
         if (lg_err[rcnt-1] == 0) okcnt++;
      end
      check(okcnt == free_exp, "R10", "successful enqueues before exhaustion", okcnt, free_exp);
      check(lg_err[rcnt-1] == 1, "R10", "enqueue at empty free list", lg_err[rcnt-1], 1);

      // random mix
      for (int i = 0; i < 300; i++) begin
         int r, op;
         r = int'($urandom % 16);
         if (r < 5) op = 0; else if (r < 8) op = 1; else if (r < 9) op = 2;
         else if (r < 11) op = 3; else if (r < 12) op = 4; else if (r < 15) op = 5;
         else op = 6 + int'($urandom % 2);
         run_cmd(int'($urandom % NP), op, int'($urandom % NQ), int'($urandom % NQ), ($urandom % 3) == 0, ge);
      end

      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule